// File: doc/BRIEF.md
# Metadata branch condition evaluator

This block decides whether a selected condition holds for one belt value. Every value on the belt carries its own tag of five status bits: carry/borrow, signed overflow, zero, transient (a "none" placeholder) and invalid (not-a-result). Conditional arithmetic, pick and conditional flow operations all ask the same question: given a 4-bit condition code, the 32-bit value and its tag, is the condition taken? The block answers with one bit.

There is no global flags register. The condition reads the tag bits stored with the source value, so two values produced by different operations can be tested independently. The sign is read from the top bit of the value itself, and zero is read from the stored tag. The block is purely combinational. Fetching the source value and acting on the decision are left to the surrounding logic.

Top module: `meta_cond_eval`

## Requirements
- R1: Code 0 (always) gives taken = 1 for every value and tag.
- R2: Code 1 (definite) gives taken = 1 exactly when both the invalid and the transient tag bits are 0.
- R3: Code 2 gives taken = carry tag; code 3 gives taken = not carry tag.
- R4: Code 4 gives taken = overflow tag; code 5 gives taken = not overflow tag.
- R5: Code 6 (negative) gives taken = value bit 31; code 7 (not negative) gives its inverse.
- R6: Code 8 gives taken = zero tag; code 9 gives taken = not zero tag.
- R7: Code 10 (not positive) gives taken = zero tag OR value bit 31; code 11 (positive) gives taken = 1 only when the zero tag is 0 and value bit 31 is 0.
- R8: Code 12 gives taken = invalid tag; code 13 gives taken = not invalid tag.
- R9: Code 14 gives taken = transient tag; code 15 gives taken = not transient tag.
- R10: For every code from 2 to 15, the code with bit 0 set gives the opposite result to the code with bit 0 cleared, for the same value and tag.
- R11: Value bits 30 down to 0 have no effect on the result of any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_code | input | 4 | Condition selector, encoding as in R1 to R9 |
| value | input | 32 | Belt value under test; bit 31 is the sign |
| tag_carry | input | 1 | Carry/borrow tag of the value |
| tag_ovf | input | 1 | Signed overflow tag of the value |
| tag_zero | input | 1 | Zero tag of the value |
| tag_transient | input | 1 | Transient (none) tag of the value |
| tag_invalid | input | 1 | Invalid (not-a-result) tag of the value |
| taken | output | 1 | 1 when the selected condition holds |

## Verification
The hardest cases are tag combinations that a real producer would never emit, such as a zero tag on a value whose sign bit is set, or an invalid value that also carries flags; these decide whether "not positive" and "positive" are built from the tag and sign alone and whether "definite" ignores the arithmetic flags. The bench reaches them by sweeping all 32 tag combinations against every code and several values with the sign bit set and cleared, deliberately ignoring consistency between the value and its tag. A separate pass holds the tag and sign fixed while toggling the lower value bits to show they never reach the result.

// File: rtl/meta_cond_pkg.sv
package meta_cond_pkg;

    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int NUM_PAIRS = NUM_CODES / 2;

    typedef enum logic [CODE_W-1:0] {
        C_ALWAYS     = 4'd0,
        C_DEFINITE   = 4'd1,
        C_CARRY      = 4'd2,
        C_NO_CARRY   = 4'd3,
        C_OVF        = 4'd4,
        C_NO_OVF     = 4'd5,
        C_NEG        = 4'd6,
        C_NOT_NEG    = 4'd7,
        C_ZERO       = 4'd8,
        C_NONZERO    = 4'd9,
        C_NOT_POS    = 4'd10,
        C_POS        = 4'd11,
        C_INVALID    = 4'd12,
        C_NOT_INV    = 4'd13,
        C_TRANSIENT  = 4'd14,
        C_NOT_TRANS  = 4'd15
    } cond_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic transient;
        logic invalid;
    } meta_tag_t;

    // Pair index: each even/odd code pair shares one base predicate.
    function automatic logic [CODE_W-2:0] pair_of(input logic [CODE_W-1:0] code);
        return code[CODE_W-1:1];
    endfunction

endpackage

// File: rtl/meta_cond_base.sv
// Builds the base predicate of each code pair (the even-code sense)
// plus the "definite" predicate used by the odd code of pair 0.
module meta_cond_base
    import meta_cond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]    value,
    input  meta_tag_t            tag,
    output logic [NUM_PAIRS-1:0] base_pred,
    output logic                 definite
);
    localparam int SIGN_BIT = DATA_W - 1;

    logic sign;
    assign sign = value[SIGN_BIT];

    always_comb begin
        base_pred    = '0;
        base_pred[0] = 1'b1;                  // always
        base_pred[1] = tag.carry;
        base_pred[2] = tag.ovf;
        base_pred[3] = sign;                  // negative
        base_pred[4] = tag.zero;
        base_pred[5] = tag.zero | sign;       // not positive
        base_pred[6] = tag.invalid;
        base_pred[7] = tag.transient;
    end

    assign definite = ~(tag.invalid | tag.transient);

endmodule

// File: rtl/meta_cond_bank.sv
// Expands the base predicates into one outcome per condition code.
module meta_cond_bank
    import meta_cond_pkg::*;
(
    input  logic [NUM_PAIRS-1:0] base_pred,
    input  logic                 definite,
    output logic [NUM_CODES-1:0] outcome
);
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        assign outcome[2*k] = base_pred[k];
        if (k == 0) begin : g_special
            // Pair 0 is not a complement pair.
            assign outcome[2*k+1] = definite;
        end else begin : g_invert
            assign outcome[2*k+1] = ~base_pred[k];
        end
    end
endmodule

// File: rtl/meta_cond_select.sv
module meta_cond_select
    import meta_cond_pkg::*;
(
    input  logic [NUM_CODES-1:0] outcome,
    input  cond_e                code,
    output logic                 taken
);
    always_comb begin
        taken = outcome[code];
    end
endmodule

// File: rtl/meta_cond_eval.sv
module meta_cond_eval
    import meta_cond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CODE_W-1:0] cond_code,
    input  logic [DATA_W-1:0] value,
    input  logic              tag_carry,
    input  logic              tag_ovf,
    input  logic              tag_zero,
    input  logic              tag_transient,
    input  logic              tag_invalid,
    output logic              taken
);
    meta_tag_t             tag;
    cond_e                 code;
    logic [NUM_PAIRS-1:0]  base_pred;
    logic                  definite;
    logic [NUM_CODES-1:0]  outcome;

    always_comb begin
        tag.carry     = tag_carry;
        tag.ovf       = tag_ovf;
        tag.zero      = tag_zero;
        tag.transient = tag_transient;
        tag.invalid   = tag_invalid;
        code          = cond_e'(cond_code);
    end

    meta_cond_base #(.DATA_W(DATA_W)) u_base (
        .value     (value),
        .tag       (tag),
        .base_pred (base_pred),
        .definite  (definite)
    );

    meta_cond_bank u_bank (
        .base_pred (base_pred),
        .definite  (definite),
        .outcome   (outcome)
    );

    meta_cond_select u_sel (
        .outcome (outcome),
        .code    (code),
        .taken   (taken)
    );

endmodule

// File: rtl/meta_cond_eval_chk.sv
module meta_cond_eval_chk
    import meta_cond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic [CODE_W-1:0] cond_code,
    input logic [DATA_W-1:0] value,
    input logic              tag_carry,
    input logic              tag_ovf,
    input logic              tag_zero,
    input logic              tag_transient,
    input logic              tag_invalid,
    input logic              taken
);
    logic known;
    assign known = !$isunknown({cond_code, value, tag_carry, tag_ovf,
                                tag_zero, tag_transient, tag_invalid, taken});

    always_comb begin
        if (known) begin
            a_r1_always: assert (cond_code != 4'd0 || taken);
            a_r2_definite: assert (!(cond_code == 4'd1 && (tag_invalid || tag_transient)) || !taken);
            a_r3_carry: assert (cond_code != 4'd2 || taken == tag_carry);
            a_r5_negative: assert (cond_code != 4'd6 || taken == value[DATA_W-1]);
            a_r7_positive: assert (!(cond_code == 4'd11 && (tag_zero || value[DATA_W-1])) || !taken);
            a_r8_invalid: assert (cond_code != 4'd12 || taken == tag_invalid);
            a_r9_transient: assert (cond_code != 4'd15 || taken == !tag_transient);
        end
    end
endmodule

bind meta_cond_eval meta_cond_eval_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_meta_cond_eval.sv
module sim_meta_cond_eval;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic [3:0]  cond_code = '0;
    logic [31:0] value = '0;
    logic        tag_carry = 0, tag_ovf = 0, tag_zero = 0;
    logic        tag_transient = 0, tag_invalid = 0;
    logic        taken;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    meta_cond_eval u0 (
        .cond_code(cond_code), .value(value), .tag_carry(tag_carry),
        .tag_ovf(tag_ovf), .tag_zero(tag_zero), .tag_transient(tag_transient),
        .tag_invalid(tag_invalid), .taken(taken)
    );

    // Reference written from the requirements. tags = {carry,ovf,zero,trans,inv}
    function automatic logic ref_taken(input logic [3:0] c, input logic [31:0] v,
                                       input logic [4:0] t);
        logic cy, ov, zr, tr, iv, ng;
        {cy, ov, zr, tr, iv} = t;
        ng = v[31];
        case (c)
            4'd0:  return 1'b1;            // R1
            4'd1:  return !iv && !tr;      // R2
            4'd2:  return cy;              // R3
            4'd3:  return !cy;
            4'd4:  return ov;              // R4
            4'd5:  return !ov;
            4'd6:  return ng;              // R5
            4'd7:  return !ng;
            4'd8:  return zr;              // R6
            4'd9:  return !zr;
            4'd10: return zr || ng;        // R7
            4'd11: return !zr && !ng;
            4'd12: return iv;              // R8
            4'd13: return !iv;
            4'd14: return tr;              // R9
            default: return !tr;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4, 4'd5: return "R4";
            4'd6, 4'd7: return "R5";
            4'd8, 4'd9: return "R6";
            4'd10, 4'd11: return "R7";
            4'd12, 4'd13: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [3:0] c, input logic [31:0] v, input logic [4:0] t);
        @(negedge clk);
        cond_code = c;
        value     = v;
        {tag_carry, tag_ovf, tag_zero, tag_transient, tag_invalid} = t;
        #1;
    endtask

    task automatic check(input string req, input logic got, input logic exp,
                         input logic [3:0] c, input logic [31:0] v, input logic [4:0] t);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s code=%0d value=%h tags=%b actual=%b expected=%b",
                     req, c, v, t, got, exp);
        end
    endtask

    // Every code against all tag combinations and several values (R1..R9)
    task automatic test_code_sweep();
        logic [31:0] vals [4] = '{32'h0000_0000, 32'h8000_0000, 32'h7fff_ffff, 32'hffff_ffff};
        for (int c = 0; c < 16; c++)
            for (int t = 0; t < 32; t++)
                for (int i = 0; i < 4; i++) begin
                    apply(4'(c), vals[i], 5'(t));
                    check(req_of(4'(c)), taken, ref_taken(4'(c), vals[i], 5'(t)),
                          4'(c), vals[i], 5'(t));
                end
    endtask

    // R7 corner: zero tag on a negative value, and positive with no tags
    task automatic test_r7_corners();
        apply(4'd10, 32'h8000_0001, 5'b00100);
        check("R7", taken, 1'b1, 4'd10, 32'h8000_0001, 5'b00100);
        apply(4'd11, 32'h8000_0001, 5'b00100);
        check("R7", taken, 1'b0, 4'd11, 32'h8000_0001, 5'b00100);
        apply(4'd11, 32'h0000_0005, 5'b00000);
        check("R7", taken, 1'b1, 4'd11, 32'h0000_0005, 5'b00000);
        apply(4'd11, 32'h0000_0005, 5'b11011);
        check("R7", taken, 1'b1, 4'd11, 32'h0000_0005, 5'b11011);
    endtask

    // R2 corner: arithmetic flags do not affect definite
    task automatic test_r2_flags();
        apply(4'd1, 32'h8000_0000, 5'b11100);
        check("R2", taken, 1'b1, 4'd1, 32'h8000_0000, 5'b11100);
        apply(4'd1, 32'h0, 5'b00001);
        check("R2", taken, 1'b0, 4'd1, 32'h0, 5'b00001);
        apply(4'd1, 32'h0, 5'b00010);
        check("R2", taken, 1'b0, 4'd1, 32'h0, 5'b00010);
    endtask

    // R10: odd code is the complement of the even one for codes 2..15
    task automatic test_r10_complement();
        logic a;
        for (int p = 1; p < 8; p++)
            for (int t = 0; t < 32; t++)
                for (int s = 0; s < 2; s++) begin
                    apply(4'(2*p), {s[0], 31'h1234}, 5'(t));
                    a = taken;
                    apply(4'(2*p+1), {s[0], 31'h1234}, 5'(t));
                    check("R10", taken, ~a, 4'(2*p+1), {s[0], 31'h1234}, 5'(t));
                end
    endtask

    // R11: low value bits never change the result
    task automatic test_r11_low_bits();
        logic [31:0] v;
        for (int c = 0; c < 16; c++)
            for (int t = 0; t < 32; t += 5)
                for (int s = 0; s < 2; s++) begin
                    apply(4'(c), {s[0], 31'h0}, 5'(t));
                    for (int b = 0; b < 31; b += 3) begin
                        v = {s[0], 31'h0} | (32'h1 << b);
                        apply(4'(c), v, 5'(t));
                        check("R11", taken, ref_taken(4'(c), {s[0], 31'h0}, 5'(t)),
                              4'(c), v, 5'(t));
                    end
                end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles >= WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        test_code_sweep();
        test_r7_corners();
        test_r2_flags();
        test_r10_complement();
        test_r11_low_bits();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule